// File: doc/BRIEF.md
# SDRAM Single-Access Controller

This block turns one host request at a time into the command sequence that a synchronous DRAM needs for a single-word read or write. The host presents a flat word address, a direction flag and, for writes, a data word. It holds these while the ready output is high. On acceptance the controller splits the address into a chip index, a bank, a row and a column. It opens the row with an activate command, waits the row-to-column delay and then issues a read or write with the auto-precharge flag set. For a read it captures the word that the device returns after the CAS latency.

The access uses a burst of one. Every access closes its own row, so the controller keeps no track of open rows and needs no explicit precharge command. The ready output stays low until the precharge wait after the access has elapsed. The next activate is therefore always legal. The block starts from an already initialised device and does not schedule refresh.

Top module: `sdram_access_ctrl`

## Requirements
- R1: The flat address splits as chip = reqAddr[25], bank = reqAddr[24:23], row = reqAddr[22:10], column = reqAddr[9:0]. In the first cycle after acceptance the pins carry ACTIVE: sdCsN low for the addressed chip only (bit index = chip), sdRasN=0, sdCasN=1, sdWeN=1, sdBa = bank, sdAddr = row.
- R2: The READ or WRITE command appears exactly 3 cycles after ACTIVE. In the two cycles between them every sdCsN bit is high.
- R3: READ/WRITE encoding: sdRasN=1, sdCasN=0, sdWeN=0 for a write and 1 for a read, sdCsN and sdBa as for ACTIVE, sdAddr[9:0] = column, sdAddr[10]=1 (auto-precharge), and sdAddr[12:11]=0.
- R4: In the WRITE cycle sdDqOut carries the request's write data, sdDqOe=1 and sdDqm=2'b00. sdDqOe is 0 in every other cycle.
- R5: The word on sdDqIn in the 3rd cycle after READ is presented on rdData with rdValid high for exactly the following cycle. At all other times rdValid is low.
- R6: reqReady is low from acceptance until the 3-cycle precharge wait has elapsed. After a write it rises 4 cycles after the WRITE cycle; after a read it rises 4 cycles after the data cycle.
- R7: reqValid and request fields presented while reqReady is low have no effect: no extra command appears and the accepted access completes unchanged.
- R8: While idle, all sdCsN bits and sdRasN, sdCasN and sdWeN are high, sdDqm is 2'b11 and sdDqOe is 0.
- R9: sdDqm is 2'b00 from the READ cycle through the read data cycle, and 2'b11 outside reads and the WRITE cycle.
- R10: After reset reqReady is high, rdValid is low and the pins are idle as in R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the device |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Host request present |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 26 | Flat word address |
| reqWdata | input | 16 | Write data |
| reqReady | output | 1 | Controller idle, request accepted when valid |
| rdValid | output | 1 | Read data strobe |
| rdData | output | 16 | Captured read word |
| sdCsN | output | 2 | Per-chip select, active low |
| sdRasN | output | 1 | Row strobe, active low |
| sdCasN | output | 1 | Column strobe, active low |
| sdWeN | output | 1 | Write enable, active low |
| sdBa | output | 2 | Bank select |
| sdAddr | output | 13 | Multiplexed row / column address |
| sdDqm | output | 2 | Byte masks |
| sdDqOut | output | 16 | Data driven toward the device |
| sdDqOe | output | 1 | Data output enable |
| sdDqIn | input | 16 | Data returned by the device |

## Verification
The bench sweeps both chips, all four banks and row and column values at all-zero, all-one and alternating patterns. A mistake in splitting the address then shows up as a wrong select bit, bank or address field. It places the correct read word on the data input only in the single cycle three clocks after READ and drives its complement elsewhere. A capture that is one cycle early or late therefore returns a wrong word. Each access checks the exact cycle in which the column command appears and the exact cycle in which ready rises. Off-by-one errors in the row-to-column or precharge counts shift one of those edges. Some accesses keep a conflicting request asserted while busy, so a controller that accepts during busy cycles would emit a stray activate.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ACT, ST_RCD, ST_CMD, ST_LAT, ST_PRE
  } ctrlState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;     // latch request fields
    logic act;      // drive row activation
    logic cmd;      // drive column command
    logic rdWin;    // read window, masks open
    logic capture;  // sample device data
  } ctrlStrobe_t;
endpackage

// File: rtl/sdc_ctrl.sv
module sdc_ctrl
  import sdc_pkg::*;
#(
  parameter int TRCD = 3,
  parameter int CL   = 3,
  parameter int TRP  = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqWrite,
  output logic        reqReady,
  output ctrlStrobe_t strobe
);
  localparam int MAXC  = (TRCD > CL) ? ((TRCD > TRP) ? TRCD : TRP) : ((CL > TRP) ? CL : TRP);
  localparam int CNT_W = $clog2(MAXC + 1);
  localparam logic [CNT_W-1:0] RCD_LOAD = CNT_W'((TRCD > 1) ? TRCD - 2 : 0);
  localparam logic [CNT_W-1:0] CL_LOAD  = CNT_W'(CL - 1);
  localparam logic [CNT_W-1:0] TRP_LOAD = CNT_W'(TRP - 1);

  ctrlState_t state;
  logic [CNT_W-1:0] cnt;
  logic wrLatched;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      wrLatched <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (reqValid) begin
          state     <= ST_ACT;
          wrLatched <= reqWrite;
        end
        ST_ACT: begin
          if (TRCD > 1) begin
            state <= ST_RCD;
            cnt   <= RCD_LOAD;
          end else begin
            state <= ST_CMD;
          end
        end
        ST_RCD: begin
          if (cnt == '0) state <= ST_CMD;
          else cnt <= cnt - 1'b1;
        end
        ST_CMD: begin
          if (wrLatched) begin
            state <= ST_PRE;
            cnt   <= TRP_LOAD;
          end else begin
            state <= ST_LAT;
            cnt   <= CL_LOAD;
          end
        end
        ST_LAT: begin
          if (cnt == '0) begin
            state <= ST_PRE;
            cnt   <= TRP_LOAD;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_PRE: begin
          if (cnt == '0) state <= ST_IDLE;
          else cnt <= cnt - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    reqReady       = (state == ST_IDLE);
    strobe.load    = (state == ST_IDLE) && reqValid;
    strobe.act     = (state == ST_ACT);
    strobe.cmd     = (state == ST_CMD);
    strobe.rdWin   = ((state == ST_CMD) && !wrLatched) || (state == ST_LAT);
    strobe.capture = (state == ST_LAT) && (cnt == '0);
  end
endmodule

// File: rtl/sdc_datapath.sv
module sdc_datapath
  import sdc_pkg::*;
#(
  parameter int CHIPS  = 2,
  parameter int BANK_W = 2,
  parameter int ROW_W  = 13,
  parameter int COL_W  = 10,
  parameter int DATA_W = 16,
  parameter int AP_BIT = 10
) (
  input  logic                                        clk,
  input  logic                                        rstN,
  input  ctrlStrobe_t                                 strobe,
  input  logic                                        reqWrite,
  input  logic [$clog2(CHIPS)+BANK_W+ROW_W+COL_W-1:0] reqAddr,
  input  logic [DATA_W-1:0]                           reqWdata,
  input  logic [DATA_W-1:0]                           sdDqIn,
  output logic                                        rdValid,
  output logic [DATA_W-1:0]                           rdData,
  output logic [CHIPS-1:0]                            sdCsN,
  output logic                                        sdRasN,
  output logic                                        sdCasN,
  output logic                                        sdWeN,
  output logic [BANK_W-1:0]                           sdBa,
  output logic [ROW_W-1:0]                            sdAddr,
  output logic [DATA_W/8-1:0]                         sdDqm,
  output logic [DATA_W-1:0]                           sdDqOut,
  output logic                                        sdDqOe
);
  localparam int CHIP_W = $clog2(CHIPS);
  localparam int ROW_LO = COL_W;
  localparam int BNK_LO = COL_W + ROW_W;
  localparam int CHP_LO = COL_W + ROW_W + BANK_W;
  localparam int MASK_W = DATA_W / 8;

  logic [CHIP_W-1:0] chipR;
  logic [BANK_W-1:0] bankR;
  logic [ROW_W-1:0]  rowR;
  logic [COL_W-1:0]  colR;
  logic [DATA_W-1:0] wdataR;
  logic              wrR;
  logic              selActive;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chipR   <= '0;
      bankR   <= '0;
      rowR    <= '0;
      colR    <= '0;
      wdataR  <= '0;
      wrR     <= 1'b0;
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      if (strobe.load) begin
        chipR  <= reqAddr[CHP_LO +: CHIP_W];
        bankR  <= reqAddr[BNK_LO +: BANK_W];
        rowR   <= reqAddr[ROW_LO +: ROW_W];
        colR   <= reqAddr[0 +: COL_W];
        wdataR <= reqWdata;
        wrR    <= reqWrite;
      end
      rdValid <= strobe.capture;
      if (strobe.capture) rdData <= sdDqIn;
    end
  end

  assign selActive = strobe.act || strobe.cmd;

  for (genvar g = 0; g < CHIPS; g++) begin : g_cs
    assign sdCsN[g] = !(selActive && (chipR == CHIP_W'(g)));
  end

  always_comb begin
    sdRasN  = !strobe.act;
    sdCasN  = !strobe.cmd;
    sdWeN   = !(strobe.cmd && wrR);
    sdBa    = selActive ? bankR : '0;
    sdAddr  = '0;
    if (strobe.act) begin
      sdAddr = rowR;
    end else if (strobe.cmd) begin
      sdAddr[COL_W-1:0] = colR;
      sdAddr[AP_BIT]    = 1'b1;
    end
    sdDqOe  = strobe.cmd && wrR;
    sdDqOut = sdDqOe ? wdataR : '0;
    sdDqm   = (sdDqOe || strobe.rdWin) ? {MASK_W{1'b0}} : {MASK_W{1'b1}};
  end
endmodule

// File: rtl/sdram_access_ctrl.sv
module sdram_access_ctrl
  import sdc_pkg::*;
#(
  parameter int CHIPS  = 2,
  parameter int BANK_W = 2,
  parameter int ROW_W  = 13,
  parameter int COL_W  = 10,
  parameter int DATA_W = 16,
  parameter int AP_BIT = 10,
  parameter int TRCD   = 3,
  parameter int CL     = 3,
  parameter int TRP    = 3
) (
  input  logic                                        clk,
  input  logic                                        rstN,
  input  logic                                        reqValid,
  input  logic                                        reqWrite,
  input  logic [$clog2(CHIPS)+BANK_W+ROW_W+COL_W-1:0] reqAddr,
  input  logic [DATA_W-1:0]                           reqWdata,
  output logic                                        reqReady,
  output logic                                        rdValid,
  output logic [DATA_W-1:0]                           rdData,
  output logic [CHIPS-1:0]                            sdCsN,
  output logic                                        sdRasN,
  output logic                                        sdCasN,
  output logic                                        sdWeN,
  output logic [BANK_W-1:0]                           sdBa,
  output logic [ROW_W-1:0]                            sdAddr,
  output logic [DATA_W/8-1:0]                         sdDqm,
  output logic [DATA_W-1:0]                           sdDqOut,
  output logic                                        sdDqOe,
  input  logic [DATA_W-1:0]                           sdDqIn
);
  ctrlStrobe_t strobe;

  sdc_ctrl #(.TRCD(TRCD), .CL(CL), .TRP(TRP)) ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqReady(reqReady), .strobe(strobe)
  );

  sdc_datapath #(
    .CHIPS(CHIPS), .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W),
    .DATA_W(DATA_W), .AP_BIT(AP_BIT)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .sdDqIn(sdDqIn),
    .rdValid(rdValid), .rdData(rdData), .sdCsN(sdCsN), .sdRasN(sdRasN),
    .sdCasN(sdCasN), .sdWeN(sdWeN), .sdBa(sdBa), .sdAddr(sdAddr),
    .sdDqm(sdDqm), .sdDqOut(sdDqOut), .sdDqOe(sdDqOe)
  );
endmodule

// File: rtl/sdram_access_ctrl_chk.sv
module sdram_access_ctrl_chk #(
  parameter int CHIPS  = 2,
  parameter int BANK_W = 2,
  parameter int ROW_W  = 13,
  parameter int COL_W  = 10,
  parameter int DATA_W = 16,
  parameter int AP_BIT = 10,
  parameter int TRCD   = 3,
  parameter int CL     = 3,
  parameter int TRP    = 3
) (
  input logic                                        clk,
  input logic                                        rstN,
  input logic                                        reqValid,
  input logic                                        reqWrite,
  input logic [$clog2(CHIPS)+BANK_W+ROW_W+COL_W-1:0] reqAddr,
  input logic [DATA_W-1:0]                           reqWdata,
  input logic                                        reqReady,
  input logic                                        rdValid,
  input logic [DATA_W-1:0]                           rdData,
  input logic [CHIPS-1:0]                            sdCsN,
  input logic                                        sdRasN,
  input logic                                        sdCasN,
  input logic                                        sdWeN,
  input logic [BANK_W-1:0]                           sdBa,
  input logic [ROW_W-1:0]                            sdAddr,
  input logic [DATA_W/8-1:0]                         sdDqm,
  input logic [DATA_W-1:0]                           sdDqOut,
  input logic                                        sdDqOe,
  input logic [DATA_W-1:0]                           sdDqIn
);
  logic anySel, actCmd, rwCmd, wrCmd;
  logic [7:0] sinceAct, sinceRw;

  assign anySel = !(&sdCsN);
  assign actCmd = anySel && !sdRasN && sdCasN && sdWeN;
  assign rwCmd  = anySel && sdRasN && !sdCasN;
  assign wrCmd  = rwCmd && !sdWeN;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sinceAct <= 8'hFF;
      sinceRw  <= 8'hFF;
    end else begin
      if (actCmd) sinceAct <= 8'd1;
      else if (sinceAct != 8'hFF) sinceAct <= sinceAct + 8'd1;
      if (rwCmd) sinceRw <= 8'd1;
      else if (sinceRw != 8'hFF) sinceRw <= sinceRw + 8'd1;
    end
  end

  assert_one_chip_R1: assert property (@(posedge clk) disable iff (!rstN)
    $countones(~sdCsN) <= 1);
  assert_rcd_gap_R2: assert property (@(posedge clk) disable iff (!rstN)
    rwCmd |-> (sinceAct == 8'(TRCD)));
  assert_ap_flag_R3: assert property (@(posedge clk) disable iff (!rstN)
    rwCmd |-> sdAddr[AP_BIT]);
  assert_oe_write_only_R4: assert property (@(posedge clk) disable iff (!rstN)
    sdDqOe |-> wrCmd);
  assert_rd_pulse_R5: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |=> !rdValid);
  assert_busy_after_accept_R6: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);
  assert_trp_gap_R6: assert property (@(posedge clk) disable iff (!rstN)
    actCmd |-> (sinceRw >= 8'(TRP + 2)));
  assert_idle_pins_R8: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (!anySel && sdRasN && sdCasN && sdWeN && !sdDqOe));
endmodule

bind sdram_access_ctrl sdram_access_ctrl_chk #(
  .CHIPS(CHIPS), .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W),
  .DATA_W(DATA_W), .AP_BIT(AP_BIT), .TRCD(TRCD), .CL(CL), .TRP(TRP)
) chk_i (.*);

// File: tb/sdram_access_ctrl_tb.sv
module sdram_access_ctrl_tb_top;
  localparam int T_RCD = 3;
  localparam int T_CL  = 3;
  localparam int T_RP  = 3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [25:0] reqAddr = '0;
  logic [15:0] reqWdata = '0;
  logic        reqReady, rdValid;
  logic [15:0] rdData;
  logic [1:0]  sdCsN;
  logic        sdRasN, sdCasN, sdWeN;
  logic [1:0]  sdBa;
  logic [12:0] sdAddr;
  logic [1:0]  sdDqm;
  logic [15:0] sdDqOut;
  logic        sdDqOe;
  logic [15:0] sdDqIn = '0;

  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  sdram_access_ctrl dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqReady(reqReady),
    .rdValid(rdValid), .rdData(rdData), .sdCsN(sdCsN), .sdRasN(sdRasN),
    .sdCasN(sdCasN), .sdWeN(sdWeN), .sdBa(sdBa), .sdAddr(sdAddr),
    .sdDqm(sdDqm), .sdDqOut(sdDqOut), .sdDqOe(sdDqOe), .sdDqIn(sdDqIn)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chkIdle(input string tag);
    chk({tag, " R8 idle pins"}, {sdCsN, sdRasN, sdCasN, sdWeN, sdDqm, sdDqOe},
        {2'b11, 1'b1, 1'b1, 1'b1, 2'b11, 1'b0});
  endtask

  function automatic logic [15:0] rdPat(input logic [25:0] a);
    return a[25:10] ^ {a[9:0], a[5:0]} ^ 16'h3C5A;
  endfunction

  // one access, starting at a negedge with reqReady expected high
  task automatic access(input logic wr, input logic [25:0] a, input logic [15:0] wd,
                        input logic junk);
    logic [1:0] expCs;
    int readyCyc;
    expCs = a[25] ? 2'b01 : 2'b10;
    readyCyc = wr ? (T_RCD + T_RP + 2) : (T_RCD + T_CL + T_RP + 2);
    chk("R6 ready before accept", reqReady, 1'b1);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = wd;
    sdDqIn = ~rdPat(a);
    for (int c = 1; c <= readyCyc; c++) begin
      @(negedge clk);
      if (c == readyCyc) begin
        reqValid = 1'b0;
        chk("R6 ready returns", reqReady, 1'b1);
        chkIdle("R6");
      end else begin
        reqValid = junk;
        if (junk) begin
          reqWrite = ~wr; reqAddr = ~a; reqWdata = ~wd;
        end
        chk("R6 busy", reqReady, 1'b0);
      end
      sdDqIn = (!wr && c == T_RCD + 1 + T_CL) ? rdPat(a) : ~rdPat(a);
      if (c == 1) begin
        chk("R1 activate cmd", {sdCsN, sdRasN, sdCasN, sdWeN}, {expCs, 3'b011});
        chk("R1 bank", sdBa, a[24:23]);
        chk("R1 row", sdAddr, a[22:10]);
        chk("R4 oe low at activate", sdDqOe, 1'b0);
      end else if (c > 1 && c <= T_RCD) begin
        chk("R2 gap deselect", sdCsN, 2'b11);
        chk("R9 mask in gap", sdDqm, 2'b11);
      end else if (c == T_RCD + 1) begin
        chk("R3 column cmd", {sdCsN, sdRasN, sdCasN, sdWeN}, {expCs, 1'b1, 1'b0, ~wr});
        chk("R3 bank", sdBa, a[24:23]);
        chk("R3 column and A10", sdAddr, {2'b00, 1'b1, a[9:0]});
        chk("R4 oe at command", sdDqOe, wr);
        chk("R9 mask at command", sdDqm, 2'b00);
        if (wr) chk("R4 write data", sdDqOut, wd);
      end else if (c < readyCyc) begin
        chk("R4 oe low after command", sdDqOe, 1'b0);
        chk("R7 no stray command", sdCsN, 2'b11);
        if (!wr && c <= T_RCD + 1 + T_CL) chk("R9 mask read window", sdDqm, 2'b00);
        else chk("R9 mask closed", sdDqm, 2'b11);
      end
      if (!wr && c == T_RCD + 2 + T_CL) begin
        chk("R5 rdValid", rdValid, 1'b1);
        chk("R5 rdData", rdData, rdPat(a));
      end else begin
        chk("R5 rdValid low", rdValid, 1'b0);
      end
    end
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [12:0] rows [3];
    logic [9:0]  cols [3];
    rows[0] = 13'h0000; rows[1] = 13'h1FFF; rows[2] = 13'h0A55;
    cols[0] = 10'h3FF;  cols[1] = 10'h000;  cols[2] = 10'h2AA;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R10 ready after reset", reqReady, 1'b1);
    chk("R10 rdValid after reset", rdValid, 1'b0);
    chkIdle("R10");
    for (int ch = 0; ch < 2; ch++)
      for (int bk = 0; bk < 4; bk++)
        for (int p = 0; p < 3; p++) begin
          logic [25:0] a;
          a = {ch[0], bk[1:0], rows[p], cols[(p + bk) % 3]};
          access(1'b1, a, a[15:0] ^ 16'hA5C3, (p == 1));
          access(1'b0, a, 16'h0000, (p == 2));
        end
    repeat (4) @(negedge clk);
    chkIdle("R8 final");
    chk("R5 no late rdValid", rdValid, 1'b0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule